// File: doc/BRIEF.md
# DRAM Bank Open-Row Controller

This block sits between a simple request port and one DRAM bank, which it models inside itself as a small cycle-accurate cell array. A request carries a flat word address, a write flag and write data. The upper address bits select the row and the lower bits select the column. The controller drives a single multiplexed command address: the row goes out with an activate command and the column goes out later with a column command. The row most recently activated stays open in the sense amplifiers. A later request to that same row skips the precharge and activate steps and pays only the column latency.

A free-running refresh timer raises a refresh request at a fixed interval. The controller serves it ahead of any waiting user request. It closes the open row, precharges, activates the next row from a wrapping refresh counter, and holds that row for a restore window before it goes idle again. The command bus is also brought out at the ports, so the command stream can be observed.

States: `S_IDLE`, `S_PRECH`, `S_ACTIVATE`, `S_COLUMN`, `S_REF_PRECH`, `S_REF_ACT`, `S_REF_RESTORE`. Transitions:
- `S_IDLE` goes to `S_REF_PRECH` when refresh is pending.
- Otherwise, on an accepted request, `S_IDLE` goes to `S_COLUMN` on a row hit or to `S_PRECH` on a miss.
- `S_PRECH` goes to `S_ACTIVATE` after T_RP cycles.
- `S_ACTIVATE` goes to `S_COLUMN` after T_RCD cycles.
- `S_COLUMN` goes to `S_IDLE` after T_CL cycles.
- `S_REF_PRECH` goes to `S_REF_ACT` after T_RP cycles.
- `S_REF_ACT` goes to `S_REF_RESTORE` after T_RCD cycles.
- `S_REF_RESTORE` goes to `S_IDLE` after T_RST cycles.

Top module: `dram_bank_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rd_valid is 0, cmd_code is 0 (no-op), and no row is open, so the first access is a row miss.
- R2: Address bits [ROW_W+COL_W-1:COL_W] select the row and bits [COL_W-1:0] select the column. A read returns the data last written to that row and column.
- R3: On a row miss, a precharge (cmd_code 1) is issued in the first cycle after acceptance. An activate (cmd_code 2) with the row on cmd_addr follows T_RP cycles later. A column command (3 = read, 4 = write) with the column on cmd_addr follows T_RCD cycles after that.
- R4: On a row hit, the column command is issued in the first cycle after acceptance, and no precharge or activate is issued.
- R5: A read gives exactly one cycle of rd_valid, T_CL cycles after its column command, with the read word on rd_data. Writes never raise rd_valid.
- R6: req_ready is 0 in the cycle after a request is accepted and stays 0 until the sequence completes.
- R7: A refresh activate is issued every REF_INTERVAL cycles, delayed by at most one in-flight request sequence (T_RP+T_RCD+T_CL+1 cycles). Refresh takes priority over a waiting request.
- R8: A refresh issues a precharge and, T_RP cycles later, a refresh activate (cmd_code 5). req_ready returns exactly T_RCD+T_RST cycles after the refresh activate.
- R9: Refresh activates carry rows 0, 1, 2, ..., 2^ROW_W-1 on cmd_addr, then wrap back to 0.
- R10: A refresh closes the open row, so the next access to the previously open row is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| cmd_code | output | 3 | Bank command this cycle: 0 no-op, 1 precharge, 2 activate, 3 read, 4 write, 5 refresh activate |
| cmd_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address for the command |

## Verification
The bench sweeps every address in three orders: row-major writes, column-major reads that miss on every access, and row-major reads that mostly hit. It predicts hit or miss from its own open-row model, which the refresh activates it observes keep current. A design that took the wrong address bits as the row, or that tracked the open row badly, would put its column command at the wrong cycle or return the wrong word. A design that left the row open across a refresh would skip the precharge in the R10 case. The bench also checks the refresh row order across several wraps and the spacing between refreshes. A wrong counter wrap or a lost refresh request shows up as an out-of-order row or as a gap longer than the interval.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_PRE    = 3'd1,
        CMD_ACT    = 3'd2,
        CMD_RD     = 3'd3,
        CMD_WR     = 3'd4,
        CMD_REFACT = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRECH,
        S_ACTIVATE,
        S_COLUMN,
        S_REF_PRECH,
        S_REF_ACT,
        S_REF_RESTORE
    } state_e;

endpackage

// File: rtl/dbc_bank_array.sv
module dbc_bank_array
    import dbc_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    localparam int CA_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int ROWS  = 1 << ROW_W,
    localparam int COLS  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [CA_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [ROW_W-1:0]  sense_row;
    logic [COL_W-1:0]  col_sel;
    logic [DATA_W-1:0] row_word [ROWS];

    assign col_sel = cmd_addr[COL_W-1:0];

    // Sense amplifiers latch the row named by an activate of either kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_row <= '0;
        end else if (cmd == CMD_ACT || cmd == CMD_REFACT) begin
            sense_row <= cmd_addr[ROW_W-1:0];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [DATA_W-1:0] cells [COLS];

        always_ff @(posedge clk) begin
            if (cmd == CMD_WR && sense_row == ROW_W'(r)) begin
                cells[col_sel] <= wdata;
            end
        end

        assign row_word[r] = cells[col_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cmd == CMD_RD) begin
            rdata <= row_word[sense_row];
        end
    end

endmodule

// File: rtl/dbc_refresh_timer.sv
module dbc_refresh_timer #(
    parameter int ROW_W        = 3,
    parameter int REF_INTERVAL = 64,
    localparam int TW          = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == TW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
            ref_row  <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (tick) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
            if (ack) begin
                ref_row <= ref_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbc_sequencer.sv
module dbc_sequencer
    import dbc_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    parameter int T_CL   = 2,
    parameter int T_RST  = 2,
    localparam int REQ_W = ROW_W + COL_W,
    localparam int CA_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int MAXT_A = (T_RP > T_RCD) ? T_RP : T_RCD,
    localparam int MAXT_B = (T_CL > T_RST) ? T_CL : T_RST,
    localparam int MAXT   = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B,
    localparam int CNT_W  = $clog2(MAXT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              ref_pending,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    input  logic [DATA_W-1:0] arr_rdata,
    output cmd_e              cmd,
    output logic [CA_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    state_e            state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  dur_last;
    logic              step_done;
    logic              accept;
    logic              row_hit;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;
    logic              open_valid;
    logic [ROW_W-1:0]  open_row;

    assign in_row  = req_addr[REQ_W-1:COL_W];
    assign in_col  = req_addr[COL_W-1:0];
    assign row_hit = open_valid && (open_row == in_row);
    assign accept  = req_valid && req_ready;

    // Length of the current timed state, minus one.
    always_comb begin
        unique case (state)
            S_PRECH, S_REF_PRECH:  dur_last = CNT_W'(T_RP - 1);
            S_ACTIVATE, S_REF_ACT: dur_last = CNT_W'(T_RCD - 1);
            S_COLUMN:              dur_last = CNT_W'(T_CL - 1);
            S_REF_RESTORE:         dur_last = CNT_W'(T_RST - 1);
            default:               dur_last = '0;
        endcase
    end

    assign step_done = (cnt == dur_last);

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (ref_pending) begin
                    state_nx = S_REF_PRECH;
                end else if (req_valid) begin
                    state_nx = row_hit ? S_COLUMN : S_PRECH;
                end
            end
            S_PRECH:       if (step_done) state_nx = S_ACTIVATE;
            S_ACTIVATE:    if (step_done) state_nx = S_COLUMN;
            S_COLUMN:      if (step_done) state_nx = S_IDLE;
            S_REF_PRECH:   if (step_done) state_nx = S_REF_ACT;
            S_REF_ACT:     if (step_done) state_nx = S_REF_RESTORE;
            S_REF_RESTORE: if (step_done) state_nx = S_IDLE;
            default:       state_nx = S_IDLE;
        endcase
    end

    // State register and in-state cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
        end
    end

    // Outputs: handshake and the command of the first cycle of each state.
    always_comb begin
        req_ready = (state == S_IDLE) && !ref_pending;
        ref_ack   = (state == S_IDLE) && ref_pending;
        cmd       = CMD_NOP;
        cmd_addr  = '0;
        wr_data   = lat_wdata;
        if (cnt == '0) begin
            unique case (state)
                S_PRECH, S_REF_PRECH: cmd = CMD_PRE;
                S_ACTIVATE: begin
                    cmd      = CMD_ACT;
                    cmd_addr = CA_W'(lat_row);
                end
                S_REF_ACT: begin
                    cmd      = CMD_REFACT;
                    cmd_addr = CA_W'(lat_row);
                end
                S_COLUMN: begin
                    cmd      = lat_we ? CMD_WR : CMD_RD;
                    cmd_addr = CA_W'(lat_col);
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Request latch, open-row tracking and read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_row    <= '0;
            lat_col    <= '0;
            lat_we     <= 1'b0;
            lat_wdata  <= '0;
            open_valid <= 1'b0;
            open_row   <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            if (accept) begin
                lat_row   <= in_row;
                lat_col   <= in_col;
                lat_we    <= req_write;
                lat_wdata <= req_wdata;
            end else if (ref_ack) begin
                lat_row <= ref_row;
            end
            if (state == S_REF_PRECH) begin
                open_valid <= 1'b0;
            end else if (state == S_ACTIVATE && cnt == '0) begin
                open_valid <= 1'b1;
                open_row   <= lat_row;
            end
            rd_valid <= (state == S_COLUMN) && step_done && !lat_we;
            if ((state == S_COLUMN) && step_done && !lat_we) begin
                rd_data <= arr_rdata;
            end
        end
    end

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
    import dbc_pkg::*;
#(
    parameter int ROW_W        = 3,
    parameter int COL_W        = 3,
    parameter int DATA_W       = 8,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_CL         = 2,
    parameter int T_RST        = 2,
    parameter int REF_INTERVAL = 64,
    localparam int REQ_W       = ROW_W + COL_W,
    localparam int CA_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        cmd_code,
    output logic [CA_W-1:0]   cmd_addr
);

    cmd_e              cmd;
    logic              ref_pending;
    logic              ref_ack;
    logic [ROW_W-1:0]  ref_row;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] wr_data;

    dbc_refresh_timer #(
        .ROW_W        (ROW_W),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending),
        .ref_row (ref_row)
    );

    dbc_sequencer #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .T_RP   (T_RP),
        .T_RCD  (T_RCD),
        .T_CL   (T_CL),
        .T_RST  (T_RST)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_ack     (ref_ack),
        .arr_rdata   (arr_rdata),
        .cmd         (cmd),
        .cmd_addr    (cmd_addr),
        .wr_data     (wr_data),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    dbc_bank_array #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .cmd_addr (cmd_addr),
        .wdata    (wr_data),
        .rdata    (arr_rdata)
    );

    assign cmd_code = cmd;

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker
    import dbc_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    parameter int T_CL   = 2,
    localparam int CA_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int WAIT_LIMIT = T_RP + T_RCD + T_CL + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rd_valid,
    input logic [2:0]      cmd_code,
    input logic [CA_W-1:0] cmd_addr,
    input logic            ref_pending
);

    logic [7:0]       since_pre;
    logic [7:0]       since_rd;
    logic [7:0]       ref_wait;
    logic [ROW_W-1:0] next_ref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= 8'hFF;
            since_rd  <= 8'hFF;
            ref_wait  <= '0;
            next_ref  <= '0;
        end else begin
            since_pre <= (cmd_code == CMD_PRE) ? 8'd1 :
                         (since_pre == 8'hFF) ? since_pre : since_pre + 8'd1;
            since_rd  <= (cmd_code == CMD_RD) ? 8'd1 :
                         (since_rd == 8'hFF) ? since_rd : since_rd + 8'd1;
            ref_wait  <= ref_pending ? ref_wait + 8'd1 : 8'd0;
            if (cmd_code == CMD_REFACT) begin
                next_ref <= next_ref + 1'b1;
            end
        end
    end

    // R3: every activate comes exactly T_RP cycles after a precharge
    assert_act_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT || cmd_code == CMD_REFACT) |-> (since_pre == 8'(T_RP)));

    // R5: read data arrives T_CL cycles after the read command
    assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd == 8'(T_CL)));

    // R5: read strobe lasts one cycle
    assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: no second acceptance right after one
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: a refresh request is served within one request sequence
    assert_ref_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_wait <= 8'(WAIT_LIMIT));

    // R9: refresh rows go in wrapping order
    assert_ref_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_REFACT) |-> (cmd_addr == CA_W'(next_ref)));

endmodule

bind dram_bank_ctrl dbc_checker #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .T_RP  (T_RP),
    .T_RCD (T_RCD),
    .T_CL  (T_CL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .cmd_code    (cmd_code),
    .cmd_addr    (cmd_addr),
    .ref_pending (ref_pending)
);

// File: tb/dram_bank_ctrl_test.sv
`timescale 1ns/1ps
module dram_bank_ctrl_test;

    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int DATA_W = 8;
    localparam int T_RP = 2;
    localparam int T_RCD = 2;
    localparam int T_CL = 2;
    localparam int T_RST = 2;
    localparam int REF_INTERVAL = 64;
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;
    localparam int WORDS = ROWS * COLS;
    localparam int WIN = 2 * (T_RP + T_RCD + T_CL) + 2;
    localparam int BUSY = T_RP + T_RCD + T_CL + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [2:0] cmd_code;
    logic [COL_W-1:0] cmd_addr;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit mo_valid = 0;
    int mo_row = 0;
    int exp_ref = 0;
    int ref_seen = 0;
    int ncyc = 0;
    int last_ref = 0;
    bit pend_rdy = 0;
    int mem_model [WORDS];

    always #2 clk = ~clk;

    dram_bank_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL), .T_RST(T_RST),
        .REF_INTERVAL(REF_INTERVAL)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr)
    );

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Refresh monitor: order, spacing, restore window, open-row model.
    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            if (cmd_code == 3'd5) begin
                chk("R9 refresh row order", int'(cmd_addr) == exp_ref % ROWS,
                    int'(cmd_addr), exp_ref % ROWS);
                if (ref_seen > 0) begin
                    chk("R7 refresh spacing",
                        (ncyc - last_ref <= REF_INTERVAL + BUSY) &&
                        (ncyc - last_ref >= REF_INTERVAL - BUSY),
                        ncyc - last_ref, REF_INTERVAL);
                end
                exp_ref++;
                ref_seen++;
                last_ref = ncyc;
                mo_valid = 0;
                pend_rdy = 1;
            end else if (pend_rdy && req_ready) begin
                chk("R8 restore window", ncyc - last_ref == T_RCD + T_RST,
                    ncyc - last_ref, T_RCD + T_RST);
                pend_rdy = 0;
            end
        end
    end

    task automatic access(bit we, int addr, int data, output int col_seen);
        int row = addr / COLS;
        int col = addr % COLS;
        bit hit;
        int col_m = -1;
        int rv_m = -1;
        int rv_n = 0;
        int pre_n = 0;
        int got = 0;
        int exp_col;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr = (ROW_W+COL_W)'(addr);
        req_wdata = DATA_W'(data);
        while (!req_ready) @(negedge clk);
        hit = mo_valid && (mo_row == row);
        @(posedge clk);
        for (int m = 0; m < WIN; m++) begin
            @(negedge clk);
            if (m == 0) begin
                req_valid = 1'b0;
                chk("R6 ready low after accept", req_ready == 1'b0, int'(req_ready), 0);
            end
            if (col_m < 0 && cmd_code == 3'd1) pre_n++;
            if (col_m < 0 && cmd_code == 3'd2)
                chk("R3 activate row", int'(cmd_addr) == row, int'(cmd_addr), row);
            if (col_m < 0 && (cmd_code == 3'd3 || cmd_code == 3'd4)) begin
                col_m = m;
                mo_valid = 1;
                mo_row = row;
                chk("R2 column address", int'(cmd_addr) == col, int'(cmd_addr), col);
                chk("R3 column kind", int'(cmd_code) == (we ? 4 : 3),
                    int'(cmd_code), we ? 4 : 3);
            end
            if (rd_valid) begin
                rv_n++;
                if (rv_m < 0) begin
                    rv_m = m;
                    got = int'(rd_data);
                end
            end
        end
        exp_col = hit ? 0 : T_RP + T_RCD;
        chk(hit ? "R4 hit column timing" : "R3 miss column timing",
            col_m == exp_col, col_m, exp_col);
        chk(hit ? "R4 hit no precharge" : "R3 miss one precharge",
            pre_n == (hit ? 0 : 1), pre_n, hit ? 0 : 1);
        if (we) begin
            mem_model[addr] = data;
            chk("R5 write no strobe", rv_n == 0, rv_n, 0);
        end else begin
            chk("R5 read strobe timing", rv_m == col_m + T_CL, rv_m, col_m + T_CL);
            chk("R5 single strobe", rv_n == 1, rv_n, 1);
            chk("R2 read data", got == mem_model[addr], got, mem_model[addr]);
        end
        col_seen = col_m;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cm;
        int seen0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", req_ready == 1'b1, int'(req_ready), 1);
        chk("R1 reset rd_valid", rd_valid == 1'b0, int'(rd_valid), 0);
        chk("R1 reset cmd", cmd_code == 3'd0, int'(cmd_code), 0);

        // Row-major writes; first access must miss.
        for (int a = 0; a < WORDS; a++) begin
            access(1'b1, a, (a * 37 + 11) % 256, cm);
            if (a == 0) chk("R1 first access miss", cm == T_RP + T_RCD, cm, T_RP + T_RCD);
        end

        // Column-major reads: row changes every access.
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                access(1'b0, r * COLS + c, 0, cm);

        // Row-major reads: page-mode hits within each row.
        for (int a = 0; a < WORDS; a++)
            access(1'b0, a, 0, cm);

        // Write then read in the same open row.
        for (int c = 0; c < COLS; c++) begin
            access(1'b1, 5 * COLS + c, 200 + c, cm);
            access(1'b0, 5 * COLS + c, 0, cm);
        end

        // R10: refresh closes the open row.
        access(1'b0, 2 * COLS + 1, 0, cm);
        seen0 = ref_seen;
        while (ref_seen == seen0) @(negedge clk);
        repeat (T_RCD + T_RST + 2) @(negedge clk);
        access(1'b0, 2 * COLS + 3, 0, cm);
        chk("R10 miss after refresh", cm == T_RP + T_RCD, cm, T_RP + T_RCD);

        // Idle long enough for the refresh counter to wrap again.
        repeat (REF_INTERVAL * (ROWS + 1)) @(negedge clk);
        chk("R9 refresh counter wrapped", ref_seen > 2 * ROWS, ref_seen, 2 * ROWS + 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule